// File: doc/BRIEF.md
# Soft-Start and Protection Sequencer

This block sequences the start-up and fault response of a digitally controlled buck regulator. After reset, and once the enable input goes high, it holds the reference at zero for an initialization delay counted in switching-cycle ticks. During that delay it asks the current-limit circuit to take a fresh overcurrent sample. It then raises a digital reference code one step at a time until it reaches the full-scale target. The step period is also counted in switching-cycle ticks, so the start-up time in ticks does not depend on the switching frequency.

The two gate-drive enables stay off until the rising reference passes the digitized output voltage. A pre-charged output therefore rides up without being pulled down, and an output charged above target is left alone until the ramp ends. An overvoltage latch holds until reset and pulses the low-side enable to discharge the output. Undervoltage protection arms only once the ramp is done, and a trip shuts the converter off. Power-good reports that the ramp has finished and that the output code lies inside a window.

Top module: `softstart_seq`

## Requirements
- R1: While reset is asserted, and while enable stays low after reset, the reference code, both gate enables, power-good, the sample request and both fault latches are all 0.
- R2: One clock after enable rises, the block enters initialization. The sample request `ocp_sample_o` is 1 and the reference is 0 for exactly DELAY_TICKS ticks. On the clock edge that takes the DELAY_TICKS-th tick, the ramp starts and the sample request drops to 0.
- R3: During the ramp the reference code rises by exactly 1 every STEP_TICKS ticks, from 0 up to TARGET_CODE. It then holds at TARGET_CODE and the ramp phase ends.
- R4: When the output code is below the target, both gate enables stay 0 during the ramp until the clock after the reference code becomes strictly greater than the output code. From then on both stay 1 while the block is enabled and no fault is latched.
- R5: When the output code is at or above the target, both gate enables stay 0 for the whole ramp and turn 1 on the clock edge that ends it.
- R6: An output code strictly above OV_CODE while enabled sets the overvoltage latch on the next clock. The latch forces the high-side enable to 0. It drives the low-side enable from a phase bit that is 0 right after latching and toggles on every tick. Only reset clears the latch; the enable input does not.
- R7: After the ramp has ended, an output code strictly below UV_CODE sets the undervoltage latch on the next clock. The latch turns both gate enables and power-good off until enable is taken low, which clears it.
- R8: Taking enable low returns the block to idle on the next clock: reference 0, both gate enables 0, power-good 0. Raising it again repeats the full initialization, including a new sample request, before any ramp.
- R9: Power-good is 1 only after the ramp has ended, with no fault latched, and with PG_LO <= output code <= PG_HI. It follows the output code in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Converter enable |
| tick_i | input | 1 | One-clock pulse per switching cycle |
| vout_code_i | input | CODE_W | Digitized output voltage, same scale as the reference |
| ref_code_o | output | CODE_W | Reference code for the error amplifier |
| hs_en_o | output | 1 | High-side gate enable |
| ls_en_o | output | 1 | Low-side gate enable |
| pgood_o | output | 1 | Power-good flag |
| ocp_sample_o | output | 1 | Request to sample the overcurrent set point during initialization |
| ov_latch_o | output | 1 | Overvoltage fault latched |
| uv_latch_o | output | 1 | Undervoltage fault latched |

## Verification
The hardest conditions to reach are the two pre-bias cases. The gate enables must turn on at exactly the step where the reference first rises above a held output code, or at the last step when the output sits above target. The bench reaches these by holding the output code at a step value, and then above the target, through a whole re-initialized ramp. It counts ticks so that it samples just before and just after the crossing. The overvoltage latch must survive a disable cycle. The bench shows this by toggling enable after a trip and reading the latch and the pulsing low-side enable before it applies reset.

// File: rtl/ss_pkg.sv
package ss_pkg;
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_INIT = 3'd1,
    ST_RAMP = 3'd2,
    ST_RUN  = 3'd3,
    ST_OFF  = 3'd4
  } ss_state_e;
endpackage

// File: rtl/ss_tick_timer.sv
// Counts switching-cycle ticks for the initialization delay and the ramp step period.
module ss_tick_timer #(
  parameter int DELAY_TICKS = 1500,
  parameter int STEP_TICKS  = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_i,
  input  logic init_run_i,
  input  logic ramp_run_i,
  output logic init_done_o,
  output logic step_o
);
  localparam int DW = (DELAY_TICKS > 1) ? $clog2(DELAY_TICKS) : 1;
  localparam int SW = (STEP_TICKS > 1) ? $clog2(STEP_TICKS) : 1;
  localparam logic [DW-1:0] DLAST = DW'(DELAY_TICKS - 1);
  localparam logic [SW-1:0] SLAST = SW'(STEP_TICKS - 1);

  logic [DW-1:0] dcnt_q, dcnt_d;
  logic [SW-1:0] scnt_q, scnt_d;

  assign init_done_o = init_run_i && tick_i && (dcnt_q == DLAST);
  assign step_o      = ramp_run_i && tick_i && (scnt_q == SLAST);

  always_comb begin
    dcnt_d = dcnt_q;
    if (!init_run_i)      dcnt_d = '0;
    else if (init_done_o) dcnt_d = '0;
    else if (tick_i)      dcnt_d = dcnt_q + 1'b1;
  end

  always_comb begin
    scnt_d = scnt_q;
    if (!ramp_run_i) scnt_d = '0;
    else if (step_o) scnt_d = '0;
    else if (tick_i) scnt_d = scnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dcnt_q <= '0;
      scnt_q <= '0;
    end else begin
      dcnt_q <= dcnt_d;
      scnt_q <= scnt_d;
    end
  end
endmodule

// File: rtl/ss_ramp_gen.sv
// Stepped reference code from zero to the target.
module ss_ramp_gen #(
  parameter int CODE_W      = 10,
  parameter int TARGET_CODE = 640
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear_i,
  input  logic              step_i,
  output logic [CODE_W-1:0] ref_o,
  output logic              last_step_o
);
  localparam logic [CODE_W-1:0] TGT = CODE_W'(TARGET_CODE);

  logic [CODE_W-1:0] ref_q, ref_d;
  logic              at_tgt;

  assign at_tgt      = (ref_q == TGT);
  assign last_step_o = step_i && (ref_q == TGT - 1'b1);
  assign ref_o       = ref_q;

  always_comb begin
    ref_d = ref_q;
    if (clear_i)              ref_d = '0;
    else if (step_i && !at_tgt) ref_d = ref_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ref_q <= '0;
    else        ref_q <= ref_d;
  end
endmodule

// File: rtl/ss_fault_mon.sv
// Overvoltage latch with low-side discharge pulsing, and post-ramp undervoltage latch.
module ss_fault_mon #(
  parameter int CODE_W  = 10,
  parameter int OV_CODE = 800,
  parameter int UV_CODE = 480
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_i,
  input  logic              tick_i,
  input  logic              uv_arm_i,
  input  logic [CODE_W-1:0] vout_i,
  output logic              ov_o,
  output logic              uv_o,
  output logic              ls_pulse_o
);
  localparam logic [CODE_W-1:0] OVC = CODE_W'(OV_CODE);
  localparam logic [CODE_W-1:0] UVC = CODE_W'(UV_CODE);

  logic ov_q, ov_d, uv_q, uv_d, ph_q, ph_d;

  always_comb begin
    ov_d = ov_q | (en_i && (vout_i > OVC));
    if (!ov_q)       ph_d = 1'b0;
    else if (tick_i) ph_d = ~ph_q;
    else             ph_d = ph_q;
    if (!en_i)       uv_d = 1'b0;
    else if (uv_q)   uv_d = 1'b1;
    else             uv_d = uv_arm_i && (vout_i < UVC);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ov_q <= 1'b0;
      uv_q <= 1'b0;
      ph_q <= 1'b0;
    end else begin
      ov_q <= ov_d;
      uv_q <= uv_d;
      ph_q <= ph_d;
    end
  end

  assign ov_o       = ov_q;
  assign uv_o       = uv_q;
  assign ls_pulse_o = ph_q;
endmodule

// File: rtl/softstart_seq.sv
module softstart_seq #(
  parameter int CODE_W      = 10,
  parameter int TARGET_CODE = 640,
  parameter int OV_CODE     = 800,
  parameter int UV_CODE     = 480,
  parameter int PG_LO       = 592,
  parameter int PG_HI       = 688,
  parameter int DELAY_TICKS = 1500,
  parameter int STEP_TICKS  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_i,
  input  logic              tick_i,
  input  logic [CODE_W-1:0] vout_code_i,
  output logic [CODE_W-1:0] ref_code_o,
  output logic              hs_en_o,
  output logic              ls_en_o,
  output logic              pgood_o,
  output logic              ocp_sample_o,
  output logic              ov_latch_o,
  output logic              uv_latch_o
);
  import ss_pkg::*;

  localparam logic [CODE_W-1:0] PGL = CODE_W'(PG_LO);
  localparam logic [CODE_W-1:0] PGH = CODE_W'(PG_HI);

  ss_state_e         st_q, st_d;
  logic              sw_q, sw_d;
  logic              init_done, step, last_step;
  logic              ov, uv, ls_pulse;
  logic [CODE_W-1:0] ref_code;

  ss_tick_timer #(.DELAY_TICKS(DELAY_TICKS), .STEP_TICKS(STEP_TICKS)) u_timer (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i),
    .init_run_i(st_q == ST_INIT), .ramp_run_i(st_q == ST_RAMP),
    .init_done_o(init_done), .step_o(step)
  );

  ss_ramp_gen #(.CODE_W(CODE_W), .TARGET_CODE(TARGET_CODE)) u_ramp (
    .clk(clk), .rst_n(rst_n),
    .clear_i((st_q == ST_IDLE) || (st_q == ST_INIT) || !en_i),
    .step_i(step), .ref_o(ref_code), .last_step_o(last_step)
  );

  ss_fault_mon #(.CODE_W(CODE_W), .OV_CODE(OV_CODE), .UV_CODE(UV_CODE)) u_fault (
    .clk(clk), .rst_n(rst_n), .en_i(en_i), .tick_i(tick_i),
    .uv_arm_i(st_q == ST_RUN), .vout_i(vout_code_i),
    .ov_o(ov), .uv_o(uv), .ls_pulse_o(ls_pulse)
  );

  // Next-state logic
  always_comb begin
    st_d = st_q;
    if (!en_i) st_d = ST_IDLE;
    else begin
      case (st_q)
        ST_IDLE: st_d = ST_INIT;
        ST_INIT: if (init_done) st_d = ST_RAMP;
        ST_RAMP: if (last_step) st_d = ST_RUN;
        ST_RUN:  if (uv) st_d = ST_OFF;
        ST_OFF:  st_d = ST_OFF;
        default: st_d = ST_IDLE;
      endcase
    end
  end

  // Switching permission: held off until the ramp passes the output
  always_comb begin
    sw_d = sw_q;
    if (!en_i) sw_d = 1'b0;
    else begin
      case (st_q)
        ST_RAMP: sw_d = sw_q || (ref_code > vout_code_i) || last_step;
        ST_RUN,
        ST_OFF:  sw_d = sw_q;
        default: sw_d = 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_IDLE;
      sw_q <= 1'b0;
    end else begin
      st_q <= st_d;
      sw_q <= sw_d;
    end
  end

  assign ref_code_o   = ref_code;
  assign hs_en_o      = sw_q && !ov && !uv;
  assign ls_en_o      = ov ? ls_pulse : (sw_q && !uv);
  assign pgood_o      = (st_q == ST_RUN) && !ov && !uv &&
                        (vout_code_i >= PGL) && (vout_code_i <= PGH);
  assign ocp_sample_o = (st_q == ST_INIT);
  assign ov_latch_o   = ov;
  assign uv_latch_o   = uv;
endmodule

// File: rtl/ss_seq_checker.sv
module ss_seq_checker #(
  parameter int CODE_W      = 10,
  parameter int TARGET_CODE = 640
) (
  input logic              clk,
  input logic              rst_n,
  input logic              en_i,
  input logic [CODE_W-1:0] ref_code_o,
  input logic              hs_en_o,
  input logic              ls_en_o,
  input logic              pgood_o,
  input logic              ocp_sample_o,
  input logic              ov_latch_o,
  input logic              uv_latch_o
);
  assert_ref_monotonic_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_code_o != $past(ref_code_o)) |->
      ((ref_code_o == $past(ref_code_o) + 1'b1) || (ref_code_o == '0)));

  assert_ref_bounded_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ref_code_o <= CODE_W'(TARGET_CODE));

  assert_ov_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ov_latch_o |=> ov_latch_o);

  assert_ov_hs_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ov_latch_o |-> !hs_en_o);

  assert_uv_gates_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
    uv_latch_o |-> (!hs_en_o && !pgood_o));

  assert_disable_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_i && !ov_latch_o) |=> (ref_code_o == '0 && !hs_en_o && !ls_en_o && !pgood_o));

  assert_pg_after_ramp_R9: assert property (@(posedge clk) disable iff (!rst_n)
    pgood_o |-> (ref_code_o == CODE_W'(TARGET_CODE)));

  assert_no_gate_in_init_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ocp_sample_o |-> (!hs_en_o && ref_code_o == '0));
endmodule

bind softstart_seq ss_seq_checker #(.CODE_W(CODE_W), .TARGET_CODE(TARGET_CODE)) u_chk (
  .clk(clk), .rst_n(rst_n), .en_i(en_i), .ref_code_o(ref_code_o),
  .hs_en_o(hs_en_o), .ls_en_o(ls_en_o), .pgood_o(pgood_o),
  .ocp_sample_o(ocp_sample_o), .ov_latch_o(ov_latch_o), .uv_latch_o(uv_latch_o)
);

// File: tb/test_softstart_seq.sv
module test_softstart_seq;
  localparam int PERIOD = 10;
  localparam int CW = 8;
  localparam int TGT = 40;
  localparam int DLY = 10;
  localparam int STP = 2;

  logic clk, rst_n, en, tick;
  logic [CW-1:0] vout;
  logic [CW-1:0] ref_code;
  logic hs, ls, pg, ocp, ov, uv;

  softstart_seq #(.CODE_W(CW), .TARGET_CODE(TGT), .OV_CODE(50), .UV_CODE(30),
                  .PG_LO(36), .PG_HI(44), .DELAY_TICKS(DLY), .STEP_TICKS(STP)) i_softstart_seq (
    .clk(clk), .rst_n(rst_n), .en_i(en), .tick_i(tick), .vout_code_i(vout),
    .ref_code_o(ref_code), .hs_en_o(hs), .ls_en_o(ls), .pgood_o(pg),
    .ocp_sample_o(ocp), .ov_latch_o(ov), .uv_latch_o(uv)
  );

  typedef struct {
    string    tag;
    logic [CW-1:0] r;
    logic     h, l, p, o, v, u;
  } exp_t;

  exp_t q[$];
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  initial clk = 0;
  always #(PERIOD/2) clk = ~clk;

  // Monitor: pops expected items and compares with the current outputs
  initial begin
    forever begin
      wait (q.size() > 0);
      begin
        exp_t e;
        e = q.pop_front();
        n_chk++;
        if (ref_code !== e.r || hs !== e.h || ls !== e.l || pg !== e.p ||
            ocp !== e.o || ov !== e.v || uv !== e.u) begin
          n_bad++;
          $display("FAIL %s: got ref=%0d hs=%b ls=%b pg=%b ocp=%b ov=%b uv=%b, exp ref=%0d hs=%b ls=%b pg=%b ocp=%b ov=%b uv=%b",
                   e.tag, ref_code, hs, ls, pg, ocp, ov, uv, e.r, e.h, e.l, e.p, e.o, e.v, e.u);
        end
      end
    end
  end

  task automatic expect_out(input string tag, input int r, input bit h, input bit l,
                            input bit p, input bit o, input bit v, input bit u);
    exp_t e;
    e.tag = tag; e.r = CW'(r); e.h = h; e.l = l; e.p = p; e.o = o; e.v = v; e.u = u;
    q.push_back(e);
    #1;
  endtask

  task automatic clks(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      tick = 1'b1;
      @(negedge clk);
      tick = 1'b0;
      @(negedge clk);
    end
  endtask

  initial begin
    #(PERIOD*200000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout, exp completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 0; en = 0; tick = 0; vout = '0;
    clks(3);
    expect_out("R1 in reset", 0, 0, 0, 0, 0, 0, 0);
    rst_n = 1;
    clks(2);
    expect_out("R1 idle after reset", 0, 0, 0, 0, 0, 0, 0);

    // Normal start from zero output
    en = 1; clks(1);
    expect_out("R2 init entered", 0, 0, 0, 0, 1, 0, 0);
    ticks(DLY - 1);
    expect_out("R2 delay not yet done", 0, 0, 0, 0, 1, 0, 0);
    ticks(1);
    expect_out("R2 ramp begins", 0, 0, 0, 0, 0, 0, 0);
    ticks(1);
    expect_out("R3 no step after one tick", 0, 0, 0, 0, 0, 0, 0);
    ticks(1);
    expect_out("R4 first step switches on", 1, 1, 1, 0, 0, 0, 0);
    vout = 8'd40;
    ticks(2 * 10);
    expect_out("R3 step count mid ramp", 11, 1, 1, 0, 0, 0, 0);
    ticks(2 * 29 - 1);
    expect_out("R3 one tick before end", 39, 1, 1, 0, 0, 0, 0);
    ticks(1);
    expect_out("R9 ramp done in window", 40, 1, 1, 1, 0, 0, 0);
    ticks(6);
    expect_out("R3 holds at target", 40, 1, 1, 1, 0, 0, 0);
    vout = 8'd45;
    #1;
    expect_out("R9 above window", 40, 1, 1, 0, 0, 0, 0);
    vout = 8'd36;
    #1;
    expect_out("R9 window low edge", 40, 1, 1, 1, 0, 0, 0);
    @(negedge clk);

    // Disable and pre-bias below target
    en = 0; clks(1);
    expect_out("R8 disable clears", 0, 0, 0, 0, 0, 0, 0);
    vout = 8'd20;
    en = 1; clks(1);
    expect_out("R8 re-init with new sample", 0, 0, 0, 0, 1, 0, 0);
    ticks(DLY);
    ticks(2 * 20);
    expect_out("R4 ref equals prebias, still off", 20, 0, 0, 0, 0, 0, 0);
    ticks(2);
    expect_out("R4 ref above prebias, on", 21, 1, 1, 0, 0, 0, 0);
    vout = 8'd40;
    ticks(2 * 19);
    expect_out("R9 second ramp done", 40, 1, 1, 1, 0, 0, 0);

    // Undervoltage after ramp
    vout = 8'd29;
    clks(1);
    expect_out("R7 undervoltage latched", 40, 0, 0, 0, 0, 0, 1);
    vout = 8'd40;
    clks(2);
    expect_out("R7 stays off", 40, 0, 0, 0, 0, 0, 1);
    en = 0; clks(1);
    expect_out("R7 disable clears uv", 0, 0, 0, 0, 0, 0, 0);

    // Pre-bias above target
    vout = 8'd46;
    en = 1; clks(1);
    ticks(DLY);
    ticks(2 * TGT - 1);
    expect_out("R5 off through ramp", 39, 0, 0, 0, 0, 0, 0);
    ticks(1);
    expect_out("R5 on at ramp end", 40, 1, 1, 0, 0, 0, 0);
    vout = 8'd31;
    clks(1);
    expect_out("R7 no trip at UV edge", 40, 1, 1, 0, 0, 0, 0);

    // Overvoltage
    vout = 8'd50;
    clks(1);
    expect_out("R6 at threshold no trip", 40, 1, 1, 0, 0, 0, 0);
    vout = 8'd60;
    clks(1);
    expect_out("R6 ov latched ls low", 40, 0, 0, 0, 0, 1, 0);
    vout = 8'd40;
    ticks(1);
    expect_out("R6 ls pulses high", 40, 0, 1, 0, 0, 1, 0);
    ticks(1);
    expect_out("R6 ls pulses low", 40, 0, 0, 0, 0, 1, 0);
    en = 0; clks(1);
    expect_out("R6 survives disable", 0, 0, 0, 0, 0, 1, 0);
    en = 1; clks(1);
    expect_out("R6 re-enable still latched", 0, 0, 0, 0, 1, 1, 0);
    rst_n = 0; en = 0; clks(1);
    expect_out("R6 reset clears ov", 0, 0, 0, 0, 0, 0, 0);
    rst_n = 1; clks(2);

    wait (q.size() == 0);
    #1;
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule